// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block carries out the state changes a processor core makes when it takes an exception. The core presents one-cycle request strobes for four causes: bus fault, non-maskable interrupt, software break and external interrupt. Alongside them it presents the vector candidate for each cause, the current program counter, the delay-slot offset, the flags word and both stack pointers. While idle, the block picks the winning cause, records a return address and a cause word, fetches the handler address from the vector table through a request/valid memory port, and then presents the new program counter, flags word and stack pointer together with a one-cycle `done` strobe.

The return address is wound back by the delay-slot offset, so an exception taken in a branch shadow runs the branch again. The flags word is pushed up as a stack of mode bits, which leaves the low bits clear and drops the core out of user mode. When the core was in user mode, the stack pointers are swapped. A bus fault that arrives while a bus fault is still being entered raises a sticky fatal flag instead of nesting.

Top module: `exc_entry_seq`

## Requirements
- R1: When several strobes arrive in the same idle cycle, the bus fault wins, then the non-maskable interrupt, then the break, then the external interrupt. The vector used is `bf_vec`, the constant 0, `brk_vec` or `irq_vec` respectively.
- R2: A non-maskable interrupt writes the return address to `nmi_ret_ptr` only. Every other cause writes it to `ret_ptr` only. The pointer not selected keeps its value.
- R3: `cause_word` becomes the 8-bit vector in bits 15:8, with every other bit zero.
- R4: The saved return address equals `cur_pc - dly_slot_off`. `dly_clr` pulses together with `done` exactly when `dly_slot_off` was nonzero at acceptance.
- R5: `mem_req` is high for exactly one cycle, with `mem_addr = base_addr + 4*vector`. Read data is taken only on a later cycle in which `mem_rvalid` is high, and `pc_new` equals that data.
- R6: `flags_new` keeps old bits 31:30, holds old bits 19:0 in bits 29:10, and has bits 9:0 zero. For a non-maskable interrupt, old bit 9 (the NMI-enable bit) is cleared before this move, so `flags_new[19]` is 0.
- R7: When old flags bit 8 (user mode) is set, `usr_sp_save` takes `sp_cur`, `sp_new` equals `kern_sp` and `sp_we` pulses with `done`. Otherwise `sp_we` stays low, `sp_new` equals `sp_cur` and `usr_sp_save` is unchanged.
- R8: A `req_bfault` strobe while a bus fault is being entered (acceptance through `done`) sets `fatal`, which stays high until reset. A `req_bfault` strobe during any other cause's entry leaves `fatal` low.
- R9: Strobes are accepted only while idle. Strobes during a sequence start no second sequence and change no output. `done` is a single-cycle pulse.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_bfault | input | 1 | Bus fault strobe |
| req_nmi | input | 1 | Non-maskable interrupt strobe |
| req_brk | input | 1 | Software break strobe |
| req_irq | input | 1 | External interrupt strobe |
| brk_vec | input | 8 | Vector latched by the break instruction |
| bf_vec | input | 8 | Vector from the translation unit |
| irq_vec | input | 8 | Vector from the interrupt controller |
| cur_pc | input | 32 | Program counter at the exception |
| dly_slot_off | input | 2 | Delay-slot offset, 0 when not in a slot |
| base_addr | input | 32 | Vector table base |
| flags_cur | input | 32 | Current flags word |
| sp_cur | input | 32 | Current stack pointer |
| kern_sp | input | 32 | Kernel stack pointer value |
| mem_req | output | 1 | Vector fetch request |
| mem_addr | output | 32 | Vector fetch address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ret_ptr | output | 32 | Exception return address |
| nmi_ret_ptr | output | 32 | NMI return address |
| cause_word | output | 32 | Cause word holding the vector |
| usr_sp_save | output | 32 | Saved user stack pointer |
| pc_new | output | 32 | Handler address |
| flags_new | output | 32 | Pushed flags word |
| sp_new | output | 32 | New stack pointer |
| sp_we | output | 1 | Stack pointer write strobe |
| dly_clr | output | 1 | Delay-slot clear strobe |
| done | output | 1 | Entry complete strobe |
| fatal | output | 1 | Nested bus fault flag, sticky |

## Verification
Two functions coincide in the commit cycle: the flag push and the stack swap both depend on the same latched flags word. A non-maskable interrupt taken in user mode also clears the NMI-enable bit in that same update. The bench enters with bit 8 and bit 9 set together and checks both the pushed word and the swapped stack pointer against a model. Cause arbitration also collides, when several strobes land in one idle cycle. The bench fires all four at once and then successive subsets, and the vector reflected in `cause_word` and `mem_addr` shows which cause won.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN  = 32;
    localparam int VEC_W = 8;
    localparam int NCAUSE = 4;

    typedef enum logic [1:0] {
        CAUSE_BFLT = 2'd0,
        CAUSE_NMI  = 2'd1,
        CAUSE_BRK  = 2'd2,
        CAUSE_IRQ  = 2'd3
    } exc_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SAVE  = 3'd1,
        ST_FETCH = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } exc_state_e;

    typedef struct packed {
        exc_state_e       state;
        exc_cause_e       cause;
        logic [VEC_W-1:0] vec;
        logic [XLEN-1:0]  fetch_addr;
        logic [XLEN-1:0]  ret_addr;
        logic [XLEN-1:0]  flags_lat;
        logic [XLEN-1:0]  sp_lat;
        logic [XLEN-1:0]  ksp_lat;
        logic             in_slot;
        logic [XLEN-1:0]  ret_ptr;
        logic [XLEN-1:0]  nmi_ret_ptr;
        logic [XLEN-1:0]  cause_word;
        logic [XLEN-1:0]  usr_sp;
        logic [XLEN-1:0]  pc_new;
        logic [XLEN-1:0]  flags_new;
        logic [XLEN-1:0]  sp_new;
        logic             swap;
        logic             fatal;
    } exc_regs_t;
endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
    parameter int N  = 4,
    parameter int VW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][VW-1:0] vec_in,
    output logic                 any,
    output logic [IW-1:0]        idx,
    output logic [VW-1:0]        vec
);
    // index 0 has the highest priority
    always_comb begin
        any = 1'b0;
        idx = '0;
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
                vec = vec_in[i];
            end
        end
    end
endmodule

// File: rtl/exc_flag_push.sv
module exc_flag_push #(
    parameter int W     = 32,
    parameter int KEEP  = 2,
    parameter int SHIFT = 10,
    localparam int MOVE = W - KEEP - SHIFT
) (
    input  logic [W-1:0] flags_in,
    output logic [W-1:0] flags_out
);
    assign flags_out = {flags_in[W-1 -: KEEP], flags_in[MOVE-1:0], {SHIFT{1'b0}}};
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int DS_W    = 2,
    parameter int U_BIT   = 8,
    parameter int M_BIT   = 9,
    parameter int KEEP_HI = 2,
    parameter int PUSH    = 10,
    parameter int IDX_LSB = 8,
    localparam int IW     = $clog2(NCAUSE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_bfault,
    input  logic             req_nmi,
    input  logic             req_brk,
    input  logic             req_irq,
    input  logic [VEC_W-1:0] brk_vec,
    input  logic [VEC_W-1:0] bf_vec,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [DS_W-1:0]  dly_slot_off,
    input  logic [XLEN-1:0]  base_addr,
    input  logic [XLEN-1:0]  flags_cur,
    input  logic [XLEN-1:0]  sp_cur,
    input  logic [XLEN-1:0]  kern_sp,
    output logic             mem_req,
    output logic [XLEN-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  ret_ptr,
    output logic [XLEN-1:0]  nmi_ret_ptr,
    output logic [XLEN-1:0]  cause_word,
    output logic [XLEN-1:0]  usr_sp_save,
    output logic [XLEN-1:0]  pc_new,
    output logic [XLEN-1:0]  flags_new,
    output logic [XLEN-1:0]  sp_new,
    output logic             sp_we,
    output logic             dly_clr,
    output logic             done,
    output logic             fatal
);
    exc_regs_t q, d;

    logic [NCAUSE-1:0]            req_vec;
    logic [NCAUSE-1:0][VEC_W-1:0] vec_arr;
    logic                         arb_any;
    logic [IW-1:0]                arb_idx;
    logic [VEC_W-1:0]             arb_vec;
    logic [XLEN-1:0]              flags_pre;
    logic [XLEN-1:0]              flags_pushed;

    assign req_vec = {req_irq, req_brk, req_nmi, req_bfault};
    assign vec_arr[CAUSE_BFLT] = bf_vec;
    assign vec_arr[CAUSE_NMI]  = '0;
    assign vec_arr[CAUSE_BRK]  = brk_vec;
    assign vec_arr[CAUSE_IRQ]  = irq_vec;

    exc_prio_arb #(.N(NCAUSE), .VW(VEC_W)) u_arb (
        .req    (req_vec),
        .vec_in (vec_arr),
        .any    (arb_any),
        .idx    (arb_idx),
        .vec    (arb_vec)
    );

    always_comb begin
        flags_pre = q.flags_lat;
        if (q.cause == CAUSE_NMI) flags_pre[M_BIT] = 1'b0;
    end

    exc_flag_push #(.W(XLEN), .KEEP(KEEP_HI), .SHIFT(PUSH)) u_push (
        .flags_in  (flags_pre),
        .flags_out (flags_pushed)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (arb_any) begin
                    d.state      = ST_SAVE;
                    d.cause      = exc_cause_e'(arb_idx);
                    d.vec        = arb_vec;
                    d.fetch_addr = base_addr + (XLEN'(arb_vec) << 2);
                    d.ret_addr   = cur_pc - XLEN'(dly_slot_off);
                    d.in_slot    = (dly_slot_off != '0);
                    d.flags_lat  = flags_cur;
                    d.sp_lat     = sp_cur;
                    d.ksp_lat    = kern_sp;
                end
            end
            ST_SAVE: begin
                if (q.cause == CAUSE_NMI) d.nmi_ret_ptr = q.ret_addr;
                else                      d.ret_ptr     = q.ret_addr;
                d.cause_word = XLEN'(q.vec) << IDX_LSB;
                d.state      = ST_FETCH;
            end
            ST_FETCH: d.state = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    d.pc_new    = mem_rdata;
                    d.flags_new = flags_pushed;
                    d.swap      = q.flags_lat[U_BIT];
                    if (q.flags_lat[U_BIT]) begin
                        d.usr_sp = q.sp_lat;
                        d.sp_new = q.ksp_lat;
                    end else begin
                        d.sp_new = q.sp_lat;
                    end
                    d.state = ST_DONE;
                end
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
        if (q.state != ST_IDLE && q.cause == CAUSE_BFLT && req_bfault)
            d.fatal = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done        = (q.state == ST_DONE);
    assign mem_req     = (q.state == ST_FETCH);
    assign mem_addr    = q.fetch_addr;
    assign ret_ptr     = q.ret_ptr;
    assign nmi_ret_ptr = q.nmi_ret_ptr;
    assign cause_word  = q.cause_word;
    assign usr_sp_save = q.usr_sp;
    assign pc_new      = q.pc_new;
    assign flags_new   = q.flags_new;
    assign sp_new      = q.sp_new;
    assign sp_we       = done & q.swap;
    assign dly_clr     = done & q.in_slot;
    assign fatal       = q.fatal;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XW      = 32,
    parameter int IDX_LSB = 8,
    parameter int VW      = 8,
    parameter int PUSH    = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          mem_req,
    input logic          mem_rvalid,
    input logic [XW-1:0] cause_word,
    input logic [XW-1:0] flags_new,
    input logic          fatal
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_no_early_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !done);
    p_done_after_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_rvalid));
    p_cause_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_word[IDX_LSB-1:0] == '0) && (cause_word[XW-1:IDX_LSB+VW] == '0));
    p_low_flags_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_new[PUSH-1:0] == '0));
    p_fatal_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);
endmodule

bind exc_entry_seq exc_entry_chk #(.XW(32), .IDX_LSB(IDX_LSB), .VW(8), .PUSH(PUSH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .cause_word (cause_word),
    .flags_new  (flags_new),
    .fatal      (fatal)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic req_bfault = 0, req_nmi = 0, req_brk = 0, req_irq = 0;
    logic [7:0] brk_vec = 0, bf_vec = 0, irq_vec = 0;
    logic [31:0] cur_pc = 0, base_addr = 0, flags_cur = 0, sp_cur = 0, kern_sp = 0;
    logic [1:0] dly_slot_off = 0;
    logic mem_req, mem_rvalid = 0;
    logic [31:0] mem_addr, mem_rdata = 0;
    logic [31:0] ret_ptr, nmi_ret_ptr, cause_word, usr_sp_save, pc_new, flags_new, sp_new;
    logic sp_we, dly_clr, done, fatal;

    exc_entry_seq i_exc_entry_seq (.*);

    typedef struct {
        logic [31:0] rp, nrp, cw, usp, pc, fl, sp, addr;
        logic        we, dc;
    } exp_t;

    exp_t exp_q[$];
    exp_t addr_q[$];
    int checks = 0, fails = 0, done_seen = 0, done_exp = 0, lat = 1;
    logic [31:0] m_rp = 0, m_nrp = 0, m_usp = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // memory model with variable latency; address checked against model (R5)
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                exp_t e;
                e = addr_q.pop_front();
                chk("R5/R1 mem_addr", mem_addr, e.addr);
                repeat (lat) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(mem_addr);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = 32'hDEAD_BEEF;
            end
        end
    end

    // monitor: pop and compare on each done
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                done_seen++;
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9 unexpected done actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R2/R4 ret_ptr", ret_ptr, e.rp);
                    chk("R2/R4 nmi_ret_ptr", nmi_ret_ptr, e.nrp);
                    chk("R3 cause_word", cause_word, e.cw);
                    chk("R5 pc_new", pc_new, e.pc);
                    chk("R6 flags_new", flags_new, e.fl);
                    chk("R7 sp_new", sp_new, e.sp);
                    chk("R7 usr_sp_save", usr_sp_save, e.usp);
                    chk("R7 sp_we", {31'b0, sp_we}, {31'b0, e.we});
                    chk("R4 dly_clr", {31'b0, dly_clr}, {31'b0, e.dc});
                end
            end
        end
    end

    // driver: rq bit0 bus fault, bit1 nmi, bit2 break, bit3 irq
    task automatic run_exc(input logic [3:0] rq, input logic [7:0] bv, input logic [7:0] fv,
                           input logic [7:0] iv, input logic [31:0] pc, input logic [1:0] ds,
                           input logic [31:0] fl, input logic [31:0] sp, input logic [31:0] ks,
                           input logic [31:0] base, input int lt, input logic [3:0] mid);
        exp_t e;
        logic [7:0] v;
        logic [31:0] f, ret;
        bit nmi;
        nmi = 0;
        if (rq[0])      v = fv;
        else if (rq[1]) begin v = 8'h00; nmi = 1; end
        else if (rq[2]) v = bv;
        else            v = iv;
        ret = pc - {30'b0, ds};
        if (nmi) m_nrp = ret; else m_rp = ret;
        f = fl;
        if (nmi) f[9] = 1'b0;
        e.fl = {f[31:30], f[19:0], 10'b0};
        if (fl[8]) begin m_usp = sp; e.sp = ks; e.we = 1; end
        else begin e.sp = sp; e.we = 0; end
        e.rp = m_rp; e.nrp = m_nrp; e.usp = m_usp;
        e.cw = {16'b0, v, 8'b0};
        e.addr = base + {22'b0, v, 2'b00};
        e.pc = mem_word(e.addr);
        e.dc = (ds != 0);
        exp_q.push_back(e);
        addr_q.push_back(e);
        done_exp++;
        lat = lt;
        brk_vec = bv; bf_vec = fv; irq_vec = iv; cur_pc = pc; dly_slot_off = ds;
        flags_cur = fl; sp_cur = sp; kern_sp = ks; base_addr = base;
        {req_irq, req_brk, req_nmi, req_bfault} = rq;
        @(negedge clk);
        {req_irq, req_brk, req_nmi, req_bfault} = mid;
        @(negedge clk);
        {req_irq, req_brk, req_nmi, req_bfault} = 4'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset outputs", ret_ptr | nmi_ret_ptr | cause_word | usr_sp_save | pc_new |
            flags_new | sp_new | {27'b0, done, mem_req, sp_we, dly_clr, fatal}, 32'h0);

        // break, kernel mode, no slot
        run_exc(4'b0100, 8'h21, 8'h33, 8'h44, 32'h0000_1000, 2'd0, 32'hC00F_F0FF & ~32'h100,
                32'h8000_0000, 32'h9000_0000, 32'h0001_0000, 1, 4'b0);
        // NMI in user mode with NMI-enable set, in a delay slot (R6/R7 together)
        run_exc(4'b0010, 8'h21, 8'h33, 8'h44, 32'h0000_2008, 2'd2, 32'h4000_0300,
                32'h7000_0010, 32'h6000_0020, 32'h0002_0000, 2, 4'b0);
        // bus fault, user mode, slot
        run_exc(4'b0001, 8'h01, 8'hFF, 8'h02, 32'h1234_5678, 2'd2, 32'hFFFF_FFFF,
                32'h1111_1110, 32'h2222_2220, 32'h0000_0400, 3, 4'b0);
        // external interrupt, kernel mode
        run_exc(4'b1000, 8'h01, 8'h02, 8'h7E, 32'h0000_0004, 2'd0, 32'h0000_0000,
                32'h0000_1000, 32'h0000_2000, 32'hFFFF_FC00, 1, 4'b0);
        // R1 priority: all four, then subsets
        run_exc(4'b1111, 8'h11, 8'h22, 8'h33, 32'h0000_3000, 2'd0, 32'h0, 32'h10, 32'h20,
                32'h0003_0000, 1, 4'b0);
        run_exc(4'b1110, 8'h11, 8'h22, 8'h33, 32'h0000_3100, 2'd0, 32'h0, 32'h10, 32'h20,
                32'h0003_0000, 2, 4'b0);
        run_exc(4'b1100, 8'h11, 8'h22, 8'h33, 32'h0000_3200, 2'd1, 32'h0, 32'h10, 32'h20,
                32'h0003_0000, 1, 4'b0);
        // R9/R8: break with bus fault and irq strobes mid-sequence: ignored, no fatal
        run_exc(4'b0100, 8'h05, 8'h06, 8'h07, 32'h0000_4000, 2'd0, 32'h100, 32'h30, 32'h40,
                32'h0004_0000, 3, 4'b1001);
        repeat (8) @(negedge clk);
        chk("R9 ignored strobes done count", done_seen, done_exp);
        chk("R9 ret_ptr after ignored", ret_ptr, m_rp);
        chk("R8 fatal low after other cause", {31'b0, fatal}, 32'h0);
        // R8: nested bus fault raises fatal
        run_exc(4'b0001, 8'h05, 8'h06, 8'h07, 32'h0000_5000, 2'd0, 32'h0, 32'h30, 32'h40,
                32'h0005_0000, 1, 4'b0001);
        chk("R8 fatal set", {31'b0, fatal}, 32'h1);
        repeat (4) @(negedge clk);
        chk("R8 fatal sticky", {31'b0, fatal}, 32'h1);
        chk("R9 total done count", done_seen, done_exp);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule